// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a 16-bit down-counting interval timer sitting on a simple register port. Software programs an interval into a modulus register, sets bits in a control/status register and reads the live count back at any time. Each count step is one timer tick: either one per clock, or one per 64 clocks when the divide-by-64 prescaler option is selected. When the count is zero and another tick arrives, the counter has expired. Expiry raises a sticky interrupt flag, and the interrupt output follows that flag whenever the interrupt enable is set.

The block has two ways of starting intervals. In periodic use, the reload bit refills the counter from the modulus on each expiry, so events repeat every modulus+1 ticks. In one-shot use, the overwrite bit makes every modulus write load the counter at once, so each write starts a fresh interval. With reload clear, the counter wraps from zero to 0xFFFF and keeps counting. Software clears the flag by writing 1 to its bit. Intervals shorter than about 0x3F ticks are legal but give software little time to respond.

Top module: `itmr_top`

## Requirements
- R1: After reset the control register reads 0x0000, the modulus and count registers read 0xFFFF, and irq is low.
- R2: Address 0 is control/status. Its bits are: [0] enable, [1] reload, [2] interrupt flag, [3] interrupt enable, [4] overwrite and [5] divide-by-64 select. Address 1 is the modulus, address 2 is the read-only count and address 3 reads zero. Read data is combinational from the address.
- R3: A control write that takes enable from 0 to 1 loads the count from the modulus and zeroes the prescaler. A control write while enable is already 1 does not restart the count.
- R4: While enabled, each tick lowers the count by one. With bit 5 clear, a tick occurs on every clock. With bit 5 set, a tick occurs every 64 clocks, and the first one comes 64 clocks after enable.
- R5: A tick at count zero is an expiry and sets the flag. With reload set, the count then becomes the modulus, giving one expiry per modulus+1 ticks.
- R6: With reload clear, an expiry wraps the count to 0xFFFF.
- R7: Writing 1 to flag bit 2 clears the flag, and writing 0 leaves it unchanged. An expiry in the same cycle as a clearing write wins.
- R8: irq is high exactly while the flag and the interrupt enable are both set.
- R9: With overwrite set, a modulus write loads the count in the same cycle and restarts the prescaler. With overwrite clear, a modulus write does not disturb the count.
- R10: While disabled, the count holds its value, the prescaler stays at zero and no expiry occurs.
- R11: Writes to the count address and to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the bus issues at most one write per cycle, and that reset is held for at least one clock edge before any write. They also assume that a start from enable and an overwrite load never arrive in the same cycle. That holds by construction, because the two come from writes to different addresses. The stimulus drives every input at the falling edge and reads only through the combinational read port. Each test first disables the timer and clears the flag, so every expected count follows from the number of rising edges since the enabling write.

// File: rtl/itmr_pkg.sv
// Package: shared register addresses and control bit positions for the
// interval timer. Assumes a 2-bit word address on the register port.
package itmr_pkg;
    localparam int CNT_W = 16;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_MOD  = 2'd1,
        A_CNT  = 2'd2,
        A_RSV  = 2'd3
    } reg_addr_e;

    localparam int B_EN   = 0;
    localparam int B_RLD  = 1;
    localparam int B_FLAG = 2;
    localparam int B_IE   = 3;
    localparam int B_OVW  = 4;
    localparam int B_DIV  = 5;
endpackage

// File: rtl/itmr_regs.sv
// Register file: control bits, modulus, sticky flag and the read mux.
// Assumes at most one write per cycle; expire comes from the counter.
module itmr_regs
    import itmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      count,
    input  logic              expire,
    output logic [W-1:0]      rdata,
    output logic [W-1:0]      modulus,
    output logic              en,
    output logic              rld,
    output logic              ie,
    output logic              div_sel,
    output logic              flag,
    output logic              start,
    output logic              load
);
    logic ovw;
    logic ctrl_wr, mod_wr;

    assign ctrl_wr = we && (addr == A_CTRL);
    assign mod_wr  = we && (addr == A_MOD);
    assign start   = ctrl_wr && wdata[B_EN] && !en;
    assign load    = mod_wr && ovw;

    // Control bits are replaced wholesale on a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0; rld <= 1'b0; ie <= 1'b0; ovw <= 1'b0; div_sel <= 1'b0;
        end else if (ctrl_wr) begin
            en      <= wdata[B_EN];
            rld     <= wdata[B_RLD];
            ie      <= wdata[B_IE];
            ovw     <= wdata[B_OVW];
            div_sel <= wdata[B_DIV];
        end
    end

    // Modulus register, full width
    always_ff @(posedge clk) begin
        if (!rst_n)      modulus <= '1;
        else if (mod_wr) modulus <= wdata;
    end

    // Sticky flag: expiry sets, write-1 clears, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n)                           flag <= 1'b0;
        else if (expire)                      flag <= 1'b1;
        else if (ctrl_wr && wdata[B_FLAG])    flag <= 1'b0;
    end

    // Combinational read mux
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: begin
                rdata[B_EN]   = en;
                rdata[B_RLD]  = rld;
                rdata[B_FLAG] = flag;
                rdata[B_IE]   = ie;
                rdata[B_OVW]  = ovw;
                rdata[B_DIV]  = div_sel;
            end
            A_MOD:   rdata = modulus;
            A_CNT:   rdata = count;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/itmr_prescale.sv
// Prescaler: produces the timer tick, every clock or every DIV clocks.
// Assumes DIV >= 2; counter is held at zero while disabled or restarted.
module itmr_prescale #(
    parameter int DIV = 64,
    localparam int PC_W = $clog2(DIV)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            div_sel,
    input  logic            restart,
    output logic            tick,
    output logic [PC_W-1:0] pc
);
    logic at_end;
    assign at_end = (pc == PC_W'(DIV - 1));
    assign tick   = en && (!div_sel || at_end);

    // Divider phase counter
    always_ff @(posedge clk) begin
        if (!rst_n || !en || restart || !div_sel) pc <= '0;
        else if (at_end)                          pc <= '0;
        else                                      pc <= pc + 1'b1;
    end
endmodule

// File: rtl/itmr_counter.sv
// Down counter: load, start, reload or wrap on expiry, decrement per tick.
// Assumes start and load are never high together.
module itmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         start,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] modulus,
    input  logic         rld,
    output logic [W-1:0] count,
    output logic         expire
);
    logic at_zero;
    assign at_zero = (count == '0);
    assign expire  = tick && at_zero && !load && !start;

    // Counter update with load > start > tick priority
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '1;
        else if (load)  count <= load_val;
        else if (start) count <= modulus;
        else if (tick) begin
            if (at_zero) count <= rld ? modulus : '1;
            else         count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/itmr_top.sv
// Top: interval timer with register port and level interrupt output.
// Assumes a single-master port with one access per cycle.
module itmr_top
    import itmr_pkg::*;
#(
    parameter int W   = CNT_W,
    parameter int DIV = 64,
    localparam int PC_W = $clog2(DIV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              irq
);
    logic [W-1:0]    count, modulus;
    logic            en, rld, ie, div_sel, flag, start, load, tick, expire;
    logic [PC_W-1:0] pc;

    itmr_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .count(count), .expire(expire),
        .rdata(bus_rdata), .modulus(modulus), .en(en), .rld(rld),
        .ie(ie), .div_sel(div_sel), .flag(flag), .start(start), .load(load)
    );

    itmr_prescale #(.DIV(DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .div_sel(div_sel),
        .restart(start | load), .tick(tick), .pc(pc)
    );

    itmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .load(load),
        .load_val(bus_wdata), .modulus(modulus), .rld(rld),
        .count(count), .expire(expire)
    );

    assign irq = flag && ie;
endmodule

// File: rtl/itmr_chk.sv
// Checker: temporal properties of the interval timer, bound to itmr_top.
module itmr_chk
    import itmr_pkg::*;
#(
    parameter int W = 16,
    parameter int PC_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      count,
    input logic [W-1:0]      modulus,
    input logic              en,
    input logic              rld,
    input logic              tick,
    input logic              load,
    input logic              start,
    input logic              expire,
    input logic              flag,
    input logic [PC_W-1:0]   pc
);
    // R4
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !start && count != '0) |=> count == W'($past(count) - 1'b1));
    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && count == '0 && rld) |=> count == $past(modulus));
    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && count == '0 && !rld) |=> count == '1);
    // R5
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(count) == '0 && $past(tick)));
    // R7
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CTRL && bus_wdata[B_FLAG] && !expire) |=> !flag);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load && !start) |=> $stable(count));
    // R10
    pre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> pc == '0);
endmodule

bind itmr_top itmr_chk #(.W(W), .PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .count(count), .modulus(modulus), .en(en),
    .rld(rld), .tick(tick), .load(load), .start(start), .expire(expire),
    .flag(flag), .pc(pc)
);

// File: tb/tb_itmr_top.sv
// Bench: vector table for periodic/wrap counting, then directed tests.
module tb_itmr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        irq;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    itmr_top dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // {modulus, ticks, reload, expected count, expected flag}
    localparam logic [49:0] VEC [8] = '{
        {16'd10,    16'd3,   1'b1, 16'd7,     1'b0},
        {16'd10,    16'd11,  1'b1, 16'd10,    1'b1},
        {16'd10,    16'd15,  1'b1, 16'd6,     1'b1},
        {16'd5,     16'd6,   1'b0, 16'hFFFF,  1'b1},
        {16'd5,     16'd9,   1'b0, 16'hFFFC,  1'b1},
        {16'h0040,  16'h0040,1'b1, 16'd0,     1'b0},
        {16'h003F,  16'd100, 1'b1, 16'h001B,  1'b1},
        {16'hFFFF,  16'd20,  1'b0, 16'hFFEB,  1'b0}
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
        rd(2'd1, v); chk("R1 modulus", v, 16'hFFFF);
        rd(2'd2, v); chk("R1 count", v, 16'hFFFF);
        chk("R1 irq", {15'd0, irq}, 16'd0);

        // R4 R5 R6 table walk, tick every clock
        for (int i = 0; i < 8; i++) begin
            wr(2'd0, 16'h0004);
            wr(2'd1, VEC[i][49:34]);
            wr(2'd0, {14'd0, VEC[i][17], 1'b1});
            edges(int'(VEC[i][33:18]));
            rd(2'd2, v); chk("R5/R6 table count", v, VEC[i][16:1]);
            rd(2'd0, v); chk("R5 table flag", {15'd0, v[2]}, {15'd0, VEC[i][0]});
        end

        // R3 R7 no restart on re-enable, W1C semantics
        wr(2'd0, 16'h0004);
        wr(2'd1, 16'd4);
        wr(2'd0, 16'h0003);
        edges(5);
        rd(2'd0, v); chk("R5 flag set", {15'd0, v[2]}, 16'd1);
        wr(2'd0, 16'h0003);
        rd(2'd2, v); chk("R3 no restart", v, 16'd2);
        rd(2'd0, v); chk("R7 write 0 keeps flag", {15'd0, v[2]}, 16'd1);
        wr(2'd0, 16'h0007);
        rd(2'd0, v); chk("R7 write 1 clears", {15'd0, v[2]}, 16'd0);
        rd(2'd2, v); chk("R4 count", v, 16'd0);

        // R8 interrupt output
        wr(2'd0, 16'h0004);
        wr(2'd1, 16'd2);
        wr(2'd0, 16'h000B);
        edges(2);
        chk("R8 irq before expiry", {15'd0, irq}, 16'd0);
        edges(1);
        chk("R8 irq at flag", {15'd0, irq}, 16'd1);
        wr(2'd0, 16'h0003);
        chk("R8 irq masked", {15'd0, irq}, 16'd0);

        // R9 overwrite on and off
        wr(2'd0, 16'h0004);
        wr(2'd1, 16'd100);
        wr(2'd0, 16'h0013);
        wr(2'd1, 16'd7);
        rd(2'd2, v); chk("R9 overwrite loads", v, 16'd7);
        wr(2'd0, 16'h0004);
        wr(2'd1, 16'd100);
        wr(2'd0, 16'h0003);
        wr(2'd1, 16'd7);
        rd(2'd2, v); chk("R9 no overwrite", v, 16'd98);
        rd(2'd1, v); chk("R2 modulus readback", v, 16'd7);

        // R10 disabled holds
        wr(2'd0, 16'h0000);
        rd(2'd2, c0);
        edges(10);
        rd(2'd2, v); chk("R10 hold", v, c0);
        rd(2'd0, v); chk("R10 no flag", {15'd0, v[2]}, 16'd0);

        // R11 read-only count and reserved address
        wr(2'd2, 16'h1234);
        wr(2'd3, 16'hBEEF);
        rd(2'd2, v); chk("R11 count write ignored", v, c0);
        rd(2'd3, v); chk("R11 reserved reads 0", v, 16'd0);

        // R4 divide by 64, R6 wrap
        wr(2'd0, 16'h0004);
        wr(2'd1, 16'd2);
        wr(2'd0, 16'h0021);
        edges(63);
        rd(2'd2, v); chk("R4 div64 no tick yet", v, 16'd2);
        edges(1);
        rd(2'd2, v); chk("R4 div64 first tick", v, 16'd1);
        edges(64);
        rd(2'd2, v); chk("R4 div64 second tick", v, 16'd0);
        edges(64);
        rd(2'd2, v); chk("R6 div64 wrap", v, 16'hFFFF);
        rd(2'd0, v); chk("R5 div64 flag", {15'd0, v[2]}, 16'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule